// File: doc/BRIEF.md
# Significance Test Bit-Stream Generator

This block is the serial output stage of a wavelet coder that keeps its significance state in per-coefficient tag bits instead of coordinate lists. For each coefficient presented on its input, it receives the signed value, the current bit-plane index and the three tag bits that belong to that coefficient. These tags are the significant-pixel tag, the insignificant-pixel tag and the subtree-significance tag. A step command tells it which coding pass is running. From these inputs it builds a code of zero to three bits, shifts the code out one bit per cycle on `bit_out` with `bit_sync` high, and reports in the same step which tags the coder must update.

Coefficients enter through a valid/ready handshake. A coefficient is taken on a rising edge where `in_valid` and `in_ready` are both high. The source must hold its inputs steady while `in_valid` is high and `in_ready` is low. `in_ready` falls while two or more bits of the current code are still waiting to leave. The output stream has no back-pressure: the receiver must take a bit in every cycle where `bit_sync` is high. Tag updates appear as a one-cycle pulse, which the tag storage outside the block applies. Within a plane, the surrounding sequencer issues the refinement step first, then the pixel test, then tree encoding. The block itself holds no per-coefficient state.

Top module: `sig_bitstream_gen`

## Requirements
- R1: A coefficient is significant at plane n when bit n of its magnitude is 1, that is, when the magnitude is at least 2^n. The magnitude is the absolute value of the 16-bit two's complement input, so -32768 has magnitude 32768.
- R2: In the refinement step (`in_step`=00) with the significant-pixel tag at 1, the block emits a single bit equal to bit n of the magnitude and requests no tag update.
- R3: In the pixel test step (`in_step`=01) with the insignificant-pixel tag at 1 and the coefficient significant, the block emits 1 and then the sign bit. It also raises both `upd_clr_ip` and `upd_set_sp`.
- R4: In the pixel test step with the insignificant-pixel tag at 1 and the coefficient not significant, the block emits a single 0 and requests no tag update.
- R5: In the tree step (`in_step`=10) with both pixel tags at 0 and the coefficient significant, the block emits 1, then the sign bit, then the subtree tag, and raises `upd_set_sp`.
- R6: In the tree step with both pixel tags at 0 and the coefficient not significant, the block emits 0 and then the subtree tag, and raises `upd_set_ip`.
- R7: An accepted coefficient whose tags do not qualify it for the commanded step produces no bits and no update. This covers refinement with the significant-pixel tag at 0, pixel test with the insignificant-pixel tag at 0, tree with either pixel tag at 1, and the unused step code 11.
- R8: `bit_out` carries a code bit only in cycles where `bit_sync` is high. The bits of a code leave in order, one per consecutive cycle, with the first bit in the cycle right after acceptance.
- R9: `in_ready` is low exactly while two or more bits of the current code remain to be sent, including the cycle of the code's own first bit. Consequently a code of one bit or less lets a new coefficient in on the next edge. A coefficient held with `in_valid` high while `in_ready` is low is taken only once, after `in_ready` rises.
- R10: The tag update flags are high for exactly the one cycle after acceptance, together with the first code bit. `upd_valid` is high when any flag is high, and `upd_set_sp` and `upd_set_ip` are never high together.
- R11: The sign bit is 1 for a negative coefficient and 0 for zero or a positive coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Coefficient and command are presented |
| in_ready | output | 1 | Block can take a coefficient on this edge |
| in_coeff | input | 16 | Signed two's complement wavelet coefficient |
| in_plane | input | 4 | Current bit-plane index n |
| in_step | input | 2 | 00 refinement, 01 pixel test, 10 tree encoding, 11 unused |
| in_tag_sp | input | 1 | Significant-pixel tag of this coefficient |
| in_tag_ip | input | 1 | Insignificant-pixel tag of this coefficient |
| in_tag_tree | input | 1 | Subtree-significance tag of this coefficient |
| bit_out | output | 1 | Serial code bit |
| bit_sync | output | 1 | bit_out carries a code bit this cycle |
| upd_valid | output | 1 | Some tag update is requested this cycle |
| upd_set_sp | output | 1 | Set the significant-pixel tag |
| upd_clr_ip | output | 1 | Clear the insignificant-pixel tag |
| upd_set_ip | output | 1 | Set the insignificant-pixel tag |

## Verification
The assertions check, on every cycle, the structural rules that hold whatever the data. These are that a stalled input always coincides with bits still leaving, that an accepted non-empty code starts on the next cycle, that a three-bit code drops ready, and that the update flags come paired with stream bits and never contradict each other. Whether each bit has the right value can be shown only by the bench's scenarios, which compare the stream against codes computed from the coefficient, plane, step and tags. The same applies to whether the right tags are requested and whether held inputs are taken exactly once. These scenarios include the most negative value, zero, and planes 0 and 15.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  localparam int CODE_MAX = 3;
  localparam int LEN_W    = $clog2(CODE_MAX + 1);

  typedef enum logic [1:0] {
    STEP_REFINE  = 2'b00,
    STEP_PIXTEST = 2'b01,
    STEP_TREE    = 2'b10,
    STEP_NONE    = 2'b11
  } step_e;

  // bits[CODE_MAX-1] leaves first
  typedef struct packed {
    logic [CODE_MAX-1:0] bits;
    logic [LEN_W-1:0]    len;
    logic                set_sp;
    logic                clr_ip;
    logic                set_ip;
  } code_t;
endpackage

// File: rtl/sbg_sig_test.sv
module sbg_sig_test #(
  parameter int COEF_W  = 16,
  parameter int PLANE_W = $clog2(COEF_W)
) (
  input  logic [COEF_W-1:0]  coeff,
  input  logic [PLANE_W-1:0] plane,
  output logic               sig,
  output logic               sign
);
  logic [COEF_W-1:0] mag;

  always_comb begin
    sign = coeff[COEF_W-1];
    mag  = sign ? (~coeff + 1'b1) : coeff;
    sig  = mag[plane];
  end
endmodule

// File: rtl/sbg_code_form.sv
module sbg_code_form
  import sbg_pkg::*;
(
  input  step_e step,
  input  logic  tag_sp,
  input  logic  tag_ip,
  input  logic  tag_tree,
  input  logic  sig,
  input  logic  sign,
  output code_t code
);
  always_comb begin
    code = '0;
    unique case (step)
      STEP_REFINE: begin
        if (tag_sp) begin
          code.bits = {sig, 2'b00};
          code.len  = LEN_W'(1);
        end
      end
      STEP_PIXTEST: begin
        if (tag_ip) begin
          if (sig) begin
            code.bits   = {1'b1, sign, 1'b0};
            code.len    = LEN_W'(2);
            code.set_sp = 1'b1;
            code.clr_ip = 1'b1;
          end else begin
            code.bits = 3'b000;
            code.len  = LEN_W'(1);
          end
        end
      end
      STEP_TREE: begin
        if (!tag_sp && !tag_ip) begin
          if (sig) begin
            code.bits   = {1'b1, sign, tag_tree};
            code.len    = LEN_W'(3);
            code.set_sp = 1'b1;
          end else begin
            code.bits   = {1'b0, tag_tree, 1'b0};
            code.len    = LEN_W'(2);
            code.set_ip = 1'b1;
          end
        end
      end
      default: code = '0;
    endcase
  end
endmodule

// File: rtl/sbg_shifter.sv
module sbg_shifter #(
  parameter int W     = 3,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     ld_bits,
  input  logic [CNT_W-1:0] ld_len,
  output logic             bit_out,
  output logic             bit_sync,
  output logic             can_load
);
  logic [W-1:0]     sreg_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      sreg_q <= ld_bits;
      cnt_q  <= ld_len;
    end else if (cnt_q != '0) begin
      sreg_q <= {sreg_q[W-2:0], 1'b0};
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign bit_out  = sreg_q[W-1];
  assign bit_sync = (cnt_q != '0);
  assign can_load = (cnt_q <= CNT_W'(1));

  // R8: a code with bits left keeps the stream going next cycle
  p_busy_continues_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_sync && !can_load) |=> bit_sync);

  // R8: the last bit is followed by silence unless a new code loads
  p_drain_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(1) && !load) |=> !bit_sync);
endmodule

// File: rtl/sig_bitstream_gen.sv
module sig_bitstream_gen
  import sbg_pkg::*;
#(
  parameter int COEF_W  = 16,
  parameter int PLANE_W = $clog2(COEF_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COEF_W-1:0]  in_coeff,
  input  logic [PLANE_W-1:0] in_plane,
  input  logic [1:0]         in_step,
  input  logic               in_tag_sp,
  input  logic               in_tag_ip,
  input  logic               in_tag_tree,
  output logic               bit_out,
  output logic               bit_sync,
  output logic               upd_valid,
  output logic               upd_set_sp,
  output logic               upd_clr_ip,
  output logic               upd_set_ip
);
  logic  sig, sign, accept;
  code_t code;

  sbg_sig_test #(.COEF_W(COEF_W), .PLANE_W(PLANE_W)) u_sig (
    .coeff (in_coeff),
    .plane (in_plane),
    .sig   (sig),
    .sign  (sign)
  );

  sbg_code_form u_form (
    .step     (step_e'(in_step)),
    .tag_sp   (in_tag_sp),
    .tag_ip   (in_tag_ip),
    .tag_tree (in_tag_tree),
    .sig      (sig),
    .sign     (sign),
    .code     (code)
  );

  assign accept = in_valid && in_ready;

  sbg_shifter #(.W(CODE_MAX), .CNT_W(LEN_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .ld_bits  (code.bits),
    .ld_len   (code.len),
    .bit_out  (bit_out),
    .bit_sync (bit_sync),
    .can_load (in_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_set_sp <= 1'b0;
      upd_clr_ip <= 1'b0;
      upd_set_ip <= 1'b0;
    end else begin
      upd_set_sp <= accept && code.set_sp;
      upd_clr_ip <= accept && code.clr_ip;
      upd_set_ip <= accept && code.set_ip;
    end
  end

  assign upd_valid = upd_set_sp || upd_clr_ip || upd_set_ip;

  // R10: updates never contradict each other
  p_upd_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_set_sp && upd_set_ip));

  // R10: an update always rides with the code's first bit
  p_upd_with_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> bit_sync);

  // R3: clearing the insignificant tag always comes with setting the significant one
  p_clr_pairs_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_clr_ip |-> upd_set_sp);

  // R8: a non-empty code starts on the next cycle
  p_first_bit_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && code.len != '0) |=> bit_sync);

  // R9: a three-bit code holds off the next coefficient
  p_long_code_stalls_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && code.len == LEN_W'(3)) |=> !in_ready);

  // R9: the input stalls only while bits are leaving
  p_stall_means_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> bit_sync);
endmodule

// File: tb/sig_bitstream_gen_bench.sv
`timescale 1ns/1ps
module sig_bitstream_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_coeff = '0;
  logic [3:0]  in_plane = '0;
  logic [1:0]  in_step = '0;
  logic        in_tag_sp = 1'b0, in_tag_ip = 1'b0, in_tag_tree = 1'b0;
  logic        bit_out, bit_sync, upd_valid, upd_set_sp, upd_clr_ip, upd_set_ip;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  bit     exp_q[$];
  string  req_q[$];

  always #2.5 clk = ~clk;

  sig_bitstream_gen u_sig_bitstream_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coeff(in_coeff), .in_plane(in_plane), .in_step(in_step),
    .in_tag_sp(in_tag_sp), .in_tag_ip(in_tag_ip), .in_tag_tree(in_tag_tree),
    .bit_out(bit_out), .bit_sync(bit_sync), .upd_valid(upd_valid),
    .upd_set_sp(upd_set_sp), .upd_clr_ip(upd_clr_ip), .upd_set_ip(upd_set_ip)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected code from the requirements
  task automatic model(input logic [15:0] c, input logic [3:0] p, input logic [1:0] s,
                       input logic sp, input logic ip, input logic tr,
                       output bit b[3], output int len, output bit fsp, output bit fcl,
                       output bit fip, output string req);
    int  mag;
    bit  sg, sig;
    sg  = c[15];
    mag = sg ? (65536 - int'(c)) : int'(c);
    sig = ((mag >> p) & 1) != 0;
    len = 0; fsp = 0; fcl = 0; fip = 0; b[0] = 0; b[1] = 0; b[2] = 0;
    req = "R7";
    if (s == 2'b00 && sp) begin
      len = 1; b[0] = sig; req = "R2";
    end else if (s == 2'b01 && ip) begin
      if (sig) begin len = 2; b[0] = 1; b[1] = sg; fsp = 1; fcl = 1; req = "R3"; end
      else begin len = 1; b[0] = 0; req = "R4"; end
    end else if (s == 2'b10 && !sp && !ip) begin
      if (sig) begin len = 3; b[0] = 1; b[1] = sg; b[2] = tr; fsp = 1; req = "R5"; end
      else begin len = 2; b[0] = 0; b[1] = tr; fip = 1; req = "R6"; end
    end
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic send(input logic [15:0] c, input logic [3:0] p, input logic [1:0] s,
                      input logic sp, input logic ip, input logic tr);
    bit b[3]; int len; bit fsp, fcl, fip; string req;
    model(c, p, s, sp, ip, tr, b, len, fsp, fcl, fip, req);
    in_coeff = c; in_plane = p; in_step = s;
    in_tag_sp = sp; in_tag_ip = ip; in_tag_tree = tr; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      exp_q.push_back(b[i]);
      req_q.push_back(req);
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(upd_set_sp == fsp, {req, " R10 set_sp"}, upd_set_sp, fsp);
    check(upd_clr_ip == fcl, {req, " R10 clr_ip"}, upd_clr_ip, fcl);
    check(upd_set_ip == fip, {req, " R10 set_ip"}, upd_set_ip, fip);
    check(upd_valid == (fsp | fcl | fip), "R10 upd_valid", upd_valid, fsp | fcl | fip);
    check(bit_sync == (len != 0), "R8 first bit timing", bit_sync, len != 0);
    check(in_ready == (len <= 1), "R9 ready", in_ready, len <= 1);
  endtask

  // stream monitor (R8 order, R1 R11 values)
  always @(negedge clk) begin
    if (rst_n && bit_sync) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8/R7 unexpected bit", bit_out, -1);
      end else begin
        bit e; string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(bit_out == e, {r, " R1 R11 R8 bit value"}, bit_out, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "reset ready", in_ready, 1);
    check(bit_sync == 1'b0, "reset sync", bit_sync, 0);
    check(upd_valid == 1'b0, "reset upd", upd_valid, 0);

    // directed corners
    send(16'h8000, 4'd15, 2'b10, 0, 0, 1);  // R11 most negative, R5
    send(16'h0000, 4'd0,  2'b10, 0, 0, 1);  // R6 zero
    send(16'hFFFF, 4'd0,  2'b01, 0, 1, 0);  // R3 -1 significant at plane 0
    send(16'h0004, 4'd2,  2'b01, 0, 1, 0);  // R1 exactly 2^n, R3 positive
    send(16'h0003, 4'd2,  2'b01, 0, 1, 0);  // R4 just below 2^n
    send(16'hFFFD, 4'd1,  2'b00, 1, 0, 0);  // R2 refine |-3| bit1=1
    send(16'h0005, 4'd1,  2'b00, 1, 0, 0);  // R2 bit1=0
    send(16'h7FFF, 4'd3,  2'b00, 0, 0, 1);  // R7 refine untagged
    send(16'h7FFF, 4'd3,  2'b01, 1, 0, 1);  // R7 pixel test untagged
    send(16'h7FFF, 4'd3,  2'b10, 1, 0, 1);  // R7 tree with tag set
    send(16'h7FFF, 4'd3,  2'b11, 0, 0, 1);  // R7 unused step
    // R9 back-to-back three-bit codes: held input taken once
    send(16'hF000, 4'd12, 2'b10, 0, 0, 0);
    send(16'h1000, 4'd12, 2'b10, 0, 0, 1);
    send(16'h1000, 4'd11, 2'b10, 0, 0, 0);

    for (int k = 0; k < 600; k++) begin
      logic [15:0] c; logic [3:0] p; logic [1:0] s; logic sp, ip;
      c = 16'($urandom);
      if (($urandom % 4) == 0) c = 16'($urandom % 64) - 16'd32;
      p = 4'($urandom % 16);
      s = 2'($urandom % 4);
      sp = ($urandom % 3) == 0;
      ip = ($urandom % 3) == 0;
      send(c, p, s, sp, ip, 1'($urandom));
      if (($urandom % 5) == 0) repeat ($urandom % 4) @(negedge clk);
    end

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R8 stream drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule